// File: doc/BRIEF.md
# Two-Bit Serial-Input State Machine Built from Selectable Flip-Flop Cells

This block is a small synchronous sequential circuit. It holds two state bits, named A (the high bit) and B (the low bit). It reads one serial input bit on every clock and drives one output bit. The state follows a fixed four-state transition table. The output is a Mealy output: it depends on the present state and on the present input, so it can change within a cycle when the input changes, without waiting for a clock edge.

Each state bit is held in a generic storage cell. A parameter sets each cell to work as a D, JK or T flip-flop, and the cell updates by the characteristic equation of its kind. An excitation stage sits in front of each cell. It takes the desired next value of that bit and its present value, and from them derives the cell's inputs. Where the cell's inputs are don't-care, the excitation stage drives 0. Whatever cell kinds are chosen, the block shows the same behaviour at its ports.

The serial input is sampled on every rising edge, with no handshake. The input carries a new symbol each cycle and the block can never refuse one, so it has no valid or ready signalling and no back-pressure. The reset is synchronous and active high.

Top module: `ab_seq_machine`

## Requirements
- R1: From state AB=00, x=0 keeps the state at 00 and x=1 moves it to 01 on the next rising edge. State is read as {A,B}, with A as the high bit.
- R2: While `rst` is 1 at a rising edge, the state becomes AB=00. Before the first non-reset edge, after reset, the state reads 00.
- R3: From state 01, x=0 moves to 11 and x=1 keeps the state at 01.
- R4: From state 10, x=0 keeps the state at 10 and x=1 moves to 00.
- R5: From state 11, x=0 moves to 10 and x=1 keeps the state at 11.
- R6: `y` is 1 exactly when the present state is 10 and x=1, and 0 in every other case. It follows `x` in the same cycle, with no clock edge in between.
- R7: The sequence of states and outputs is identical for every choice of cell kind (D, JK or T) for either bit.
- R8: At most one of the two state bits changes at any rising edge.
- R9: Reset takes priority over `x`: with `rst`=1, the state becomes 00 whatever the present state and whatever the value of `x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to state 00 |
| x | input | 1 | Serial input bit, sampled every rising edge |
| y | output | 1 | Mealy output, from the present state and x |
| st_a | output | 1 | State bit A (high bit) |
| st_b | output | 1 | State bit B (low bit) |

## Verification
The state bits are brought straight out to ports, so a wrong excitation or a wrong characteristic equation in any cell shows up on `st_a` or `st_b` at the first rising edge after the faulty transition is taken. A wrong output term shows on `y` in the same cycle, as soon as the state is 10. The bench therefore reaches every state with both input values. It then runs long pseudo-random input streams through four builds that use different cell kinds, and compares them every cycle against a table model and against each other.

// File: rtl/fsm2_pkg.sv
package fsm2_pkg;
  typedef enum logic [1:0] {
    CELL_D  = 2'd0,
    CELL_JK = 2'd1,
    CELL_T  = 2'd2
  } cell_kind_e;

  localparam int STATE_W = 2;
  localparam int BIT_A   = 1;
  localparam int BIT_B   = 0;

  typedef logic [STATE_W-1:0] ab_state_t;
endpackage

// File: rtl/fsm2_next.sv
// Next-state logic in sum-of-products form.
module fsm2_next
  import fsm2_pkg::*;
(
  input  ab_state_t cur,
  input  logic      x,
  output ab_state_t nxt
);
  logic a, b;
  assign a = cur[BIT_A];
  assign b = cur[BIT_B];

  always_comb begin
    nxt        = '0;
    nxt[BIT_A] = (b & ~x) | ((b | ~x) & a);
    nxt[BIT_B] = (~a & x) | ((~a | x) & b);
  end
endmodule

// File: rtl/fsm2_mealy.sv
// Output depends on present state and present input.
module fsm2_mealy
  import fsm2_pkg::*;
(
  input  ab_state_t cur,
  input  logic      x,
  output logic      y
);
  assign y = (cur == ab_state_t'(2'b10)) & x;
endmodule

// File: rtl/fsm2_bit.sv
// One state bit: excitation logic plus a cell with the chosen characteristic equation.
module fsm2_bit
  import fsm2_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_D
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic q
);
  generate
    if (KIND == CELL_JK) begin : g_jk
      logic j, k;
      always_comb begin
        // Don't-care inputs resolved to 0.
        if (q) begin
          j = 1'b0;
          k = ~want;
        end else begin
          j = want;
          k = 1'b0;
        end
      end
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (j & ~q) | (~k & q);
      end
    end else if (KIND == CELL_T) begin : g_t
      logic t;
      always_comb t = q ^ want;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (t & ~q) | (~t & q);
      end
    end else begin : g_d
      logic d;
      always_comb d = want;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/ab_seq_machine.sv
module ab_seq_machine
  import fsm2_pkg::*;
#(
  parameter cell_kind_e CELL_A = CELL_JK,
  parameter cell_kind_e CELL_B = CELL_T
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y,
  output logic st_a,
  output logic st_b
);
  ab_state_t cur, nxt;

  fsm2_next u_next (.cur(cur), .x(x), .nxt(nxt));
  fsm2_mealy u_out (.cur(cur), .x(x), .y(y));

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    localparam cell_kind_e K = (i == BIT_A) ? CELL_A : CELL_B;
    fsm2_bit #(.KIND(K)) u_bit (
      .clk (clk),
      .rst (rst),
      .want(nxt[i]),
      .q   (cur[i])
    );
  end

  assign st_a = cur[BIT_A];
  assign st_b = cur[BIT_B];
endmodule

// File: rtl/fsm2_chk.sv
module fsm2_chk (
  input logic clk,
  input logic rst,
  input logic x,
  input logic y,
  input logic a,
  input logic b
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!a && !b)); // R2
  AST_S00_X0: assert property (@(posedge clk) disable iff (rst) (!a && !b && !x) |=> (!a && !b)); // R1
  AST_S00_X1: assert property (@(posedge clk) disable iff (rst) (!a && !b && x) |=> (!a && b)); // R1
  AST_S01_X0: assert property (@(posedge clk) disable iff (rst) (!a && b && !x) |=> (a && b)); // R3
  AST_S01_X1: assert property (@(posedge clk) disable iff (rst) (!a && b && x) |=> (!a && b)); // R3
  AST_S10_X0: assert property (@(posedge clk) disable iff (rst) (a && !b && !x) |=> (a && !b)); // R4
  AST_S10_X1: assert property (@(posedge clk) disable iff (rst) (a && !b && x) |=> (!a && !b)); // R4
  AST_S11_X0: assert property (@(posedge clk) disable iff (rst) (a && b && !x) |=> (a && !b)); // R5
  AST_S11_X1: assert property (@(posedge clk) disable iff (rst) (a && b && x) |=> (a && b)); // R5
  AST_Y_ONLY_S10: assert property (@(posedge clk) disable iff (rst) y |-> (a && !b && x)); // R6
  AST_Y_WHEN_S10: assert property (@(posedge clk) disable iff (rst) (a && !b && x) |-> y); // R6
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones({a, b} ^ {$past(a), $past(b)}) <= 1)); // R8
endmodule

bind ab_seq_machine fsm2_chk u_chk (
  .clk(clk), .rst(rst), .x(x), .y(y), .a(st_a), .b(st_b)
);

// File: tb/ab_seq_machine_tb.sv
`timescale 1ns/1ps
module ab_seq_machine_tb;
  import fsm2_pkg::*;

  localparam int NB = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic ya [NB];
  logic sa [NB];
  logic sb [NB];
  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [1:0] model = 2'b00;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ab_seq_machine #(.CELL_A(CELL_JK), .CELL_B(CELL_JK)) u_dut
    (.clk(clk), .rst(rst), .x(x), .y(ya[0]), .st_a(sa[0]), .st_b(sb[0]));
  ab_seq_machine #(.CELL_A(CELL_D), .CELL_B(CELL_D)) u_dut_d
    (.clk(clk), .rst(rst), .x(x), .y(ya[1]), .st_a(sa[1]), .st_b(sb[1]));
  ab_seq_machine #(.CELL_A(CELL_T), .CELL_B(CELL_T)) u_dut_t
    (.clk(clk), .rst(rst), .x(x), .y(ya[2]), .st_a(sa[2]), .st_b(sb[2]));
  ab_seq_machine #(.CELL_A(CELL_T), .CELL_B(CELL_JK)) u_dut_mix
    (.clk(clk), .rst(rst), .x(x), .y(ya[3]), .st_a(sa[3]), .st_b(sb[3]));

  function automatic logic [1:0] tbl_next(logic [1:0] s, logic xv);
    case (s)
      2'b00:   return xv ? 2'b01 : 2'b00;
      2'b01:   return xv ? 2'b01 : 2'b11;
      2'b10:   return xv ? 2'b00 : 2'b10;
      default: return xv ? 2'b11 : 2'b10;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] s);
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [1:0] got, logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic step(input logic xv, input logic do_rst);
    logic [1:0] prev;
    string tag;
    @(negedge clk);
    x = xv;
    rst = do_rst;
    #1;
    for (int i = 0; i < NB; i++)
      chk("R6", "y", {1'b0, ya[i]}, {1'b0, (model == 2'b10) && xv});
    prev = model;
    if (do_rst) begin
      model = 2'b00;
      tag = xv ? "R9" : "R2";
    end else begin
      model = tbl_next(prev, xv);
      tag = req_of(prev);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NB; i++)
      chk(tag, "state", {sa[i], sb[i]}, model);
    for (int i = 1; i < NB; i++)
      chk("R7", "build match", {sa[i], sb[i]}, {sa[0], sb[0]});
    if (!do_rst)
      chk("R8", "bits changed<=1", {1'b0, $countones(prev ^ {sa[0], sb[0]}) <= 1}, 2'b01);
  endtask

  task automatic reach(input logic [1:0] s);
    step(1'b1, 1'b1);
    case (s)
      2'b01: step(1'b1, 1'b0);
      2'b11: begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
      2'b10: begin step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); end
      default: ;
    endcase
  endtask

  initial begin
    rst = 1'b1;
    x = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < NB; i++)
      chk("R2", "reset state", {sa[i], sb[i]}, 2'b00);
    // Exhaustive: every state with both input values
    for (int s = 0; s < 4; s++) begin
      for (int xv = 0; xv < 2; xv++) begin
        reach(2'(s));
        step(1'(xv), 1'b0);
      end
    end
    // Reset priority from every state with x=1 (R9)
    for (int s = 0; s < 4; s++) begin
      reach(2'(s));
      step(1'b1, 1'b1);
    end
    // Long pseudo-random streams with sporadic reset
    step(1'b0, 1'b1);
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[15:11] == 5'd0);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #250000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule